// File: doc/BRIEF.md
# Six-Output Servo Slot Expander

This block turns one decoded servo pulse into six separate servo pulses. A receiver delivers two signals. The first is the pulse of the first channel in each frame. The second is a rebuilt carrier-detect waveform, which rises once at the start of every channel slot. The block synchronises both signals to its system clock. On every rising edge of the detect waveform it shifts the register one place and loads the current level of the first-channel pulse. A single one therefore enters at the start of slot 1 and moves one place per slot. Each register bit is high for exactly one channel interval, and so drives one servo.

The detect waveform trails the first-channel pulse slightly. At the first rising edge of a frame the first-channel pulse is still high, and at every later edge it is already low. The block models this delay by sampling the first-channel level one system clock after it detects the edge. The register holds more bits than there are outputs, so surplus slots have somewhere to go and stay invisible. An optional timeout empties the register when the detect waveform stops rising.

A two-state controller governs the register. `ST_EMPTY` means the register holds no ones. `ST_WALK` means at least one one is moving through it. The transitions are:
- load: `ST_EMPTY` to `ST_WALK`, taken when a shift loads a one.
- drain: `ST_WALK` to `ST_EMPTY`, taken when a shift leaves the register all zero.
- expire: `ST_WALK` to `ST_EMPTY`, taken when the timeout clears the register.

Every other case stays in the current state.

Top module: `servo_slot_expander`

## Requirements
- R1: While `rst_n` is low, the register clears and the controller is in `ST_EMPTY`. From the first clock edge after reset until the first detect rising edge, all six outputs are low.
- R2: Each rising edge of `detect_wave` causes exactly one shift. The new value appears on `servo_out` within 4 system clocks. A falling edge of `detect_wave` changes nothing.
- R3: The bit shifted into position 0 is the synchronised level of `ch1_pulse` one system clock after the detect edge is found. A high level loads 1 and a low level loads 0.
- R4: `servo_out[k]` shows register bit k. A one loaded at detect edge n is visible on `servo_out[k]` from edge n+k until edge n+k+1.
- R5: The register is 8 bits wide and only bits 0 to 5 reach the outputs. Once a one has moved into bit 6, `servo_out` no longer shows it.
- R6: Between two detect rising edges, and with no timeout, the outputs hold their value.
- R7: With the timeout enabled, the register clears and the controller returns to `ST_EMPTY` when `TIMEOUT_CYCLES` clocks pass in `ST_WALK` without a shift. Every shift restarts the count.
- R8: If `ch1_pulse` is high at several consecutive detect edges, one is loaded at each of those edges. The outputs then show a run of adjacent ones.
- R9: The controller is in `ST_WALK` exactly when the register holds at least one one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| ch1_pulse | input | 1 | First-channel pulse from the receiver; asynchronous |
| detect_wave | input | 1 | Rebuilt carrier-detect waveform; asynchronous; each rising edge starts a slot |
| servo_out | output | NUM_SERVO (6) | One pulse per servo channel; bit 0 is channel 1 |

## Verification
The assertions check on every cycle:
- the register stays still when there is neither an edge nor a timeout (R6);
- each shift moves every bit up exactly one place (R4);
- a timeout leaves the register empty (R7);
- the controller state agrees with the register contents (R9);
- the outputs are zero after reset (R1).

Only the bench's scenarios can show the rest:
- that a one lands in the right slot through the synchronisers and the sampling delay;
- that falling edges do nothing;
- that surplus slots disappear past output 5;
- that runs of ones form when the first-channel pulse stays high;
- the timing of the timeout against real gaps between edges.

The bench compares every sampled output with a shift model of its own. It covers several slot lengths, frame lengths and first-channel pulse lengths.

// File: rtl/servo_slot_pkg.sv
package servo_slot_pkg;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_WALK  = 1'b1
    } slot_state_t;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_CLEAR = 2'd2
    } slot_op_t;

endpackage

// File: rtl/servo_slot_sync.sv
module servo_slot_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q[0] <= async_in;
        end
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q[i] <= RESET_VAL;
                end else begin
                    chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/servo_slot_edge.sv
module servo_slot_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic rise_late
);

    logic prev_q;
    logic rise_now;

    assign rise_now = level_in & ~prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q    <= 1'b1;
            rise_late <= 1'b0;
        end else begin
            prev_q    <= level_in;
            rise_late <= rise_now;
        end
    end

endmodule

// File: rtl/servo_slot_shifter.sv
module servo_slot_shifter
    import servo_slot_pkg::*;
#(
    parameter int REG_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  slot_op_t            op,
    input  logic                din,
    output logic [REG_BITS-1:0] bits_q,
    output logic                shift_empties,
    output logic                occupied
);

    logic [REG_BITS-1:0] shifted;

    assign shifted       = {bits_q[REG_BITS-2:0], din};
    assign shift_empties = (shifted == '0);
    assign occupied      = |bits_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            unique case (op)
                OP_SHIFT: bits_q <= shifted;
                OP_CLEAR: bits_q <= '0;
                default:  bits_q <= bits_q;
            endcase
        end
    end

endmodule

// File: rtl/servo_slot_watchdog.sv
module servo_slot_watchdog #(
    parameter bit WDOG_EN        = 1'b1,
    parameter int TIMEOUT_CYCLES = 375000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    input  logic active,
    output logic hit
);

    localparam int CW = $clog2(TIMEOUT_CYCLES + 1);

    generate
        if (WDOG_EN) begin : g_on
            logic [CW-1:0] count_q;

            assign hit = active && !kick && (count_q == CW'(TIMEOUT_CYCLES - 1));

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    count_q <= '0;
                end else if (kick || !active || hit) begin
                    count_q <= '0;
                end else begin
                    count_q <= count_q + 1'b1;
                end
            end
        end else begin : g_off
            assign hit = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/servo_slot_expander.sv
module servo_slot_expander
    import servo_slot_pkg::*;
#(
    parameter int NUM_SERVO      = 6,
    parameter int REG_BITS       = 8,
    parameter int SYNC_STAGES    = 2,
    parameter bit WDOG_EN        = 1'b1,
    parameter int TIMEOUT_CYCLES = 375000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ch1_pulse,
    input  logic                 detect_wave,
    output logic [NUM_SERVO-1:0] servo_out
);

    logic                ch1_s;
    logic                det_s;
    logic                rise_d;
    logic                wd_hit;
    logic                shift_empties;
    logic                occupied;
    logic [REG_BITS-1:0] shift_q;
    slot_state_t         state_q;
    slot_state_t         state_d;
    slot_op_t            op;

    servo_slot_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_ch1 (
        .clk(clk), .rst_n(rst_n), .async_in(ch1_pulse), .sync_out(ch1_s)
    );

    servo_slot_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_det (
        .clk(clk), .rst_n(rst_n), .async_in(detect_wave), .sync_out(det_s)
    );

    servo_slot_edge u_edge (
        .clk(clk), .rst_n(rst_n), .level_in(det_s), .rise_late(rise_d)
    );

    servo_slot_watchdog #(.WDOG_EN(WDOG_EN), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_wdog (
        .clk(clk), .rst_n(rst_n), .kick(rise_d),
        .active(state_q == ST_WALK), .hit(wd_hit)
    );

    servo_slot_shifter #(.REG_BITS(REG_BITS)) u_shift (
        .clk(clk), .rst_n(rst_n), .op(op), .din(ch1_s),
        .bits_q(shift_q), .shift_empties(shift_empties), .occupied(occupied)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and register command
    always_comb begin
        state_d = state_q;
        op      = OP_HOLD;
        unique case (state_q)
            ST_EMPTY: begin
                if (rise_d) begin
                    op = OP_SHIFT;
                    if (ch1_s) state_d = ST_WALK;
                end
            end
            ST_WALK: begin
                if (rise_d) begin
                    op = OP_SHIFT;
                    if (shift_empties) state_d = ST_EMPTY;
                end else if (wd_hit || !occupied) begin
                    op      = OP_CLEAR;
                    state_d = ST_EMPTY;
                end
            end
            default: begin
                op      = OP_CLEAR;
                state_d = ST_EMPTY;
            end
        endcase
    end

    assign servo_out = shift_q[NUM_SERVO-1:0];

endmodule

// File: rtl/servo_slot_expander_chk.sv
module servo_slot_expander_chk
    import servo_slot_pkg::*;
#(
    parameter int NUM_SERVO = 6,
    parameter int REG_BITS  = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rise_d,
    input slot_op_t             op,
    input slot_state_t          state_q,
    input logic [REG_BITS-1:0]  shift_q,
    input logic [NUM_SERVO-1:0] servo_out
);

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (servo_out == '0))
        else $error("R1 outputs not cleared by reset");

    a_r6_hold_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |=> $stable(shift_q))
        else $error("R6 register moved without an edge");

    a_r4_walk_one_place: assert property (@(posedge clk) disable iff (!rst_n)
        rise_d |=> (shift_q[REG_BITS-1:1] == $past(shift_q[REG_BITS-2:0])))
        else $error("R4 shift did not move bits one place");

    a_r7_timeout_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CLEAR) |=> (shift_q == '0))
        else $error("R7 clear left bits set");

    a_r9_state_tracks_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WALK) == (shift_q != '0))
        else $error("R9 state disagrees with register");

endmodule

bind servo_slot_expander servo_slot_expander_chk #(
    .NUM_SERVO(NUM_SERVO), .REG_BITS(REG_BITS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rise_d(rise_d), .op(op),
    .state_q(state_q), .shift_q(shift_q), .servo_out(servo_out)
);

// File: tb/tb_servo_slot_expander.sv
`timescale 1ns/1ps
module tb_servo_slot_expander;

    localparam int NS  = 6;
    localparam int TO  = 100;
    localparam int GAP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ch1_pulse = 1'b0;
    logic          detect_wave = 1'b1;
    logic [NS-1:0] servo_out;

    int          n_checks = 0;
    int          n_fail = 0;
    int          cycles = 0;
    logic [7:0]  model = '0;

    always #4 clk = ~clk;

    servo_slot_expander #(
        .NUM_SERVO(NS), .REG_BITS(8), .SYNC_STAGES(2),
        .WDOG_EN(1'b1), .TIMEOUT_CYCLES(TO)
    ) dut (
        .clk(clk), .rst_n(rst_n), .ch1_pulse(ch1_pulse),
        .detect_wave(detect_wave), .servo_out(servo_out)
    );

    always @(posedge clk) cycles <= cycles + 1;

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [NS-1:0] exp);
        n_checks++;
        if (servo_out !== exp) begin
            n_fail++;
            $display("FAIL %s: servo_out=%b expected=%b at cycle %0d",
                     tag, servo_out, exp, cycles);
        end
    endtask

    // nedges slots; ch1 high at the first hi_edges edges
    task automatic send_frame(input int nedges, input int slot, input int hi_edges);
        for (int e = 0; e < nedges; e++) begin
            detect_wave = 1'b0;
            ch1_pulse   = (e < hi_edges);
            wait_cyc(GAP / 2);
            check("R2 falling edge ignored (R6 hold)", model[NS-1:0]);
            wait_cyc(GAP - GAP / 2);
            detect_wave = 1'b1;
            model = {model[6:0], (e < hi_edges) ? 1'b1 : 1'b0};
            wait_cyc(slot / 2);
            if (hi_edges > 1) check("R8 run of ones", model[NS-1:0]);
            else if (e >= NS) check("R5 surplus slot hidden", model[NS-1:0]);
            else check("R4 token in slot (R3 sample)", model[NS-1:0]);
            wait_cyc(slot - slot / 2);
            check("R6 hold before next edge", model[NS-1:0]);
        end
        ch1_pulse = 1'b0;
    endtask

    initial begin
        wait_cyc(5);
        check("R1 reset state", '0);
        rst_n = 1'b1;
        wait_cyc(10);
        check("R1 idle after reset", '0);

        foreach (int_slots[i]) begin end
        for (int s = 0; s < 3; s++) begin
            for (int n = 0; n < 4; n++) begin
                for (int h = 1; h <= 2; h++) begin
                    int slot;
                    int ne;
                    slot = (s == 0) ? 12 : (s == 1) ? 20 : 33;
                    ne   = (n == 0) ? 3 : (n == 1) ? 6 : (n == 2) ? 7 : 8;
                    send_frame(ne, slot, h);
                    wait_cyc(30);
                    check("R7 no early timeout", model[NS-1:0]);
                    wait_cyc(TO + 10);
                    model = '0;
                    check("R7 timeout empties", '0);
                end
            end
        end

        // ch1 low at every edge: nothing loaded (R3)
        send_frame(4, 16, 0);
        check("R3 low ch1 loads zero", '0);

        // reset in mid-frame (R1)
        send_frame(2, 16, 1);
        rst_n = 1'b0;
        wait_cyc(3);
        check("R1 reset mid-frame", '0);
        rst_n = 1'b1;
        model = '0;
        wait_cyc(10);
        check("R1 stays clear", '0);
        send_frame(3, 16, 1);
        wait_cyc(TO + 10);
        model = '0;
        check("R7 final timeout", '0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run hung, cycles=%0d expected<150000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    int int_slots[1];

endmodule